// File: doc/BRIEF.md
# Pipelined Booth Radix-4 Multiply-Accumulate Unit

This block is a signed multiply-accumulate engine for filter datapaths. Each accepted operand pair X and Y, both `OP_W` bits wide, is multiplied and added to a running total `2*OP_W` bits wide. Operand Y is recoded into radix-4 signed digits, so there is one partial-product row per two multiplier bits. Those rows pass through a carry-save reduction network that ends in two vectors: a sum and a carry. The two vectors are registered.

In the second cycle, a three-input carry-save stage merges the registered sum, the registered carry and the fed-back total. A carry-propagate add then resolves the merged pair into the new total. The clear control puts zero in place of the feedback, so a new dot product starts on the cycle right after the previous one ends, with no idle slot. Within a filter the unit runs at twice the sample clock, which gives two products per output sample.

A generate parameter picks the shape of the reduction network: a balanced tree of 3:2 compressors, or a linear carry-save array.

Top module: `mac_top`

## Requirements
- R1: For an accepted operand pair with clear high, the result is the signed product X×Y as a two's-complement value `2*OP_W` bits wide.
- R2: For an accepted pair with clear low, the result is the previous result plus the signed product X×Y.
- R3: A clear on an accepted pair discards the previous total in that same cycle, so back-to-back dot products need no idle cycle between them.
- R4: `res_vld` is high exactly two clock cycles after a cycle in which `in_vld` was high, and low otherwise.
- R5: While `res_vld` is low, `res` keeps its value.
- R6: After reset, `res` is zero and `res_vld` is low.
- R7: The running total wraps modulo 2^(2*OP_W) on overflow, with no saturation.
- R8: Extreme operands give exact products, including the most negative value times itself, which is 2^(2*OP_W-2).
- R9: When `in_vld` is low, `clr`, `op_x` and `op_y` do not change the running total. The next accepted pair without clear adds to the total that was held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Operand pair is valid this cycle |
| clr | input | 1 | Start a new total with this pair (qualified by in_vld) |
| op_x | input | OP_W | Signed multiplicand |
| op_y | input | OP_W | Signed multiplier, Booth-recoded |
| res_vld | output | 1 | New total available |
| res | output | 2*OP_W | Running signed total |

## Verification
The assertions assume that `op_x`, `op_y`, `clr` and `in_vld` hold known values in every cycle after reset. They also assume that reset is held for at least one clock edge before it is released. The bench drives every input from the first instant and keeps operands defined even on idle cycles. On those idle cycles it fills `clr` and the operands with arbitrary values, which exercises R9. Idle cycles fall between accepted pairs, so the hold property and the latency property are both checked across gaps and across back-to-back streams.

// File: rtl/mac_pkg.sv
package mac_pkg;

   typedef enum logic [2:0] {
      BD_ZERO,
      BD_POS1,
      BD_POS2,
      BD_NEG1,
      BD_NEG2
   } booth_dig_t;

   // Overlapping triple {y[2i+1], y[2i], y[2i-1]} -> signed digit
   function automatic booth_dig_t booth_decode(input logic [2:0] trip);
      booth_dig_t d;
      case (trip)
         3'b001, 3'b010: d = BD_POS1;
         3'b011:         d = BD_POS2;
         3'b100:         d = BD_NEG2;
         3'b101, 3'b110: d = BD_NEG1;
         default:        d = BD_ZERO;
      endcase
      return d;
   endfunction

   // operands left after one layer of 3:2 compressors
   function automatic int csa_next(input int n);
      return 2 * (n / 3) + (n % 3);
   endfunction

   function automatic int csa_count(input int n, input int lvl);
      int c;
      c = n;
      for (int i = 0; i < lvl; i++) c = csa_next(c);
      return c;
   endfunction

   function automatic int csa_depth(input int n);
      int c;
      int d;
      c = n;
      d = 0;
      while (c > 2) begin
         c = csa_next(c);
         d++;
      end
      return d;
   endfunction

endpackage

// File: rtl/mac_csa3.sv
module mac_csa3 #(
   parameter int W = 32
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic [W-1:0] c,
   output logic [W-1:0] s,
   output logic [W-1:0] cy
);
   assign s  = a ^ b ^ c;
   assign cy = {(a[W-2:0] & b[W-2:0]) | (a[W-2:0] & c[W-2:0]) | (b[W-2:0] & c[W-2:0]), 1'b0};
endmodule

// File: rtl/mac_booth_rows.sv
module mac_booth_rows
   import mac_pkg::*;
#(
   parameter  int OP_W = 16,
   localparam int PW   = 2 * OP_W,
   localparam int NROW = OP_W / 2
) (
   input  logic [OP_W-1:0]           mcand,
   input  logic [OP_W-1:0]           mplier,
   output logic [NROW-1:0][PW-1:0]   rows,
   output logic [PW-1:0]             neg_bits
);
   logic [OP_W:0]    y_ext;
   logic [PW-1:0]    x_ext;
   logic [NROW-1:0]  neg_v;

   assign y_ext = {mplier, 1'b0};
   assign x_ext = {{OP_W{mcand[OP_W-1]}}, mcand};

   for (genvar i = 0; i < NROW; i++) begin : g_row
      booth_dig_t   dig;
      logic [PW-1:0] mag;

      assign dig = booth_decode(y_ext[2*i+2 : 2*i]);

      always_comb begin
         case (dig)
            BD_POS1, BD_NEG1: mag = x_ext;
            BD_POS2, BD_NEG2: mag = {x_ext[PW-2:0], 1'b0};
            default:          mag = '0;
         endcase
      end

      assign neg_v[i] = (dig == BD_NEG1) || (dig == BD_NEG2);
      // one's complement here, the +1 travels in neg_bits at weight 2i
      assign rows[i]  = (neg_v[i] ? ~mag : mag) << (2 * i);
   end

   always_comb begin
      neg_bits = '0;
      for (int i = 0; i < NROW; i++) neg_bits[2*i] = neg_v[i];
   end
endmodule

// File: rtl/mac_csa_reduce.sv
module mac_csa_reduce
   import mac_pkg::*;
#(
   parameter int N_IN     = 9,
   parameter int W        = 32,
   parameter bit USE_TREE = 1'b1
) (
   input  logic [N_IN-1:0][W-1:0] ops,
   output logic [W-1:0]           sum,
   output logic [W-1:0]           carry
);
   if (N_IN < 3) begin : g_bad_n
      $error("mac_csa_reduce needs at least three operands");
   end

   if (USE_TREE) begin : g_tree
      localparam int LV = csa_depth(N_IN);
      logic [W-1:0] st [LV+1][N_IN];

      for (genvar e = 0; e < N_IN; e++) begin : g_in
         assign st[0][e] = ops[e];
      end

      for (genvar l = 0; l < LV; l++) begin : g_lvl
         localparam int NL = csa_count(N_IN, l);
         localparam int NG = NL / 3;
         localparam int NR = NL % 3;
         localparam int NN = 2 * NG + NR;

         for (genvar g = 0; g < NG; g++) begin : g_cmp
            mac_csa3 #(.W(W)) u_csa (
               .a (st[l][3*g]),
               .b (st[l][3*g+1]),
               .c (st[l][3*g+2]),
               .s (st[l+1][2*g]),
               .cy(st[l+1][2*g+1])
            );
         end
         for (genvar r = 0; r < NR; r++) begin : g_pass
            assign st[l+1][2*NG+r] = st[l][3*NG+r];
         end
         for (genvar e = NN; e < N_IN; e++) begin : g_idle
            assign st[l+1][e] = '0;
         end
      end

      assign sum   = st[LV][0];
      assign carry = st[LV][1];
   end else begin : g_array
      logic [W-1:0] cs [N_IN-1];
      logic [W-1:0] cc [N_IN-1];

      assign cs[0] = ops[0];
      assign cc[0] = ops[1];
      for (genvar i = 2; i < N_IN; i++) begin : g_step
         mac_csa3 #(.W(W)) u_csa (
            .a (cs[i-2]),
            .b (cc[i-2]),
            .c (ops[i]),
            .s (cs[i-1]),
            .cy(cc[i-1])
         );
      end

      assign sum   = cs[N_IN-2];
      assign carry = cc[N_IN-2];
   end
endmodule

// File: rtl/mac_top.sv
module mac_top #(
   parameter  int OP_W     = 16,
   parameter  bit USE_TREE = 1'b1,
   localparam int PW       = 2 * OP_W,
   localparam int NROW     = OP_W / 2,
   localparam int NOPS     = NROW + 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_vld,
   input  logic            clr,
   input  logic [OP_W-1:0] op_x,
   input  logic [OP_W-1:0] op_y,
   output logic            res_vld,
   output logic [PW-1:0]   res
);
   if (OP_W < 4 || (OP_W % 2) != 0) begin : g_bad_width
      $error("mac_top: OP_W must be even and at least 4");
   end

   logic [NROW-1:0][PW-1:0] rows;
   logic [PW-1:0]           neg_bits;
   logic [NOPS-1:0][PW-1:0] ops;
   logic [PW-1:0]           red_s, red_c;

   mac_booth_rows #(.OP_W(OP_W)) u_rows (
      .mcand   (op_x),
      .mplier  (op_y),
      .rows    (rows),
      .neg_bits(neg_bits)
   );

   for (genvar i = 0; i < NROW; i++) begin : g_ops
      assign ops[i] = rows[i];
   end
   assign ops[NROW] = neg_bits;

   mac_csa_reduce #(.N_IN(NOPS), .W(PW), .USE_TREE(USE_TREE)) u_reduce (
      .ops  (ops),
      .sum  (red_s),
      .carry(red_c)
   );

   // stage 1: sum/carry registers
   logic [PW-1:0] s_q, c_q;
   logic          vld1_q, clr1_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s_q    <= '0;
         c_q    <= '0;
         vld1_q <= 1'b0;
         clr1_q <= 1'b0;
      end else begin
         vld1_q <= in_vld;
         if (in_vld) begin
            s_q    <= red_s;
            c_q    <= red_c;
            clr1_q <= clr;
         end
      end
   end

   // stage 2: three-operand merge and final add
   logic [PW-1:0] acc_q, fb, m_s, m_c, nxt;
   logic          vld2_q;

   assign fb = clr1_q ? '0 : acc_q;

   mac_csa3 #(.W(PW)) u_merge (
      .a (s_q),
      .b (c_q),
      .c (fb),
      .s (m_s),
      .cy(m_c)
   );

   assign nxt = m_s + m_c;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q  <= '0;
         vld2_q <= 1'b0;
      end else begin
         vld2_q <= vld1_q;
         if (vld1_q) acc_q <= nxt;
      end
   end

   assign res     = acc_q;
   assign res_vld = vld2_q;
endmodule

// File: rtl/mac_chk.sv
module mac_chk #(
   parameter  int OP_W = 16,
   localparam int PW   = 2 * OP_W
) (
   input logic            clk,
   input logic            rst_n,
   input logic            in_vld,
   input logic            clr,
   input logic [OP_W-1:0] op_x,
   input logic [OP_W-1:0] op_y,
   input logic            res_vld,
   input logic [PW-1:0]   res,
   input logic [PW-1:0]   st_sum,
   input logic [PW-1:0]   st_carry,
   input logic            st_vld
);
   logic [PW-1:0] prod_now;
   logic [PW-1:0] p_d1, p_d2;
   logic          v_d1, v_d2, c_d1, c_d2;

   assign prod_now = PW'($signed(op_x) * $signed(op_y));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         p_d1 <= '0; p_d2 <= '0;
         v_d1 <= 1'b0; v_d2 <= 1'b0;
         c_d1 <= 1'b0; c_d2 <= 1'b0;
      end else begin
         p_d1 <= prod_now; p_d2 <= p_d1;
         v_d1 <= in_vld;   v_d2 <= v_d1;
         c_d1 <= clr;      c_d2 <= c_d1;
      end
   end

   // R4
   lat_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_vld == v_d2);

   // R1
   stage_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      st_vld |-> (PW'(st_sum + st_carry) == $past(prod_now)));

   // R2 R3
   acc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_vld |-> (res == (c_d2 ? p_d2 : PW'($past(res) + p_d2))));

   // R5
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !res_vld |-> $stable(res));
endmodule

bind mac_top mac_chk #(.OP_W(OP_W)) u_mac_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .in_vld  (in_vld),
   .clr     (clr),
   .op_x    (op_x),
   .op_y    (op_y),
   .res_vld (res_vld),
   .res     (res),
   .st_sum  (s_q),
   .st_carry(c_q),
   .st_vld  (vld1_q)
);

// File: tb/mac_top_bench.sv
`timescale 1ns/1ps
module mac_top_bench;
   localparam int OP_W = 6;
   localparam int PW   = 2 * OP_W;
   localparam int MASK = (1 << PW) - 1;
   localparam int XMIN = -(1 << (OP_W - 1));
   localparam int XMAX = (1 << (OP_W - 1)) - 1;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            in_vld = 1'b0;
   logic            clr = 1'b0;
   logic [OP_W-1:0] op_x = '0;
   logic [OP_W-1:0] op_y = '0;
   logic            res_vld;
   logic [PW-1:0]   res;

   always #2.5 clk = ~clk;

   mac_top #(.OP_W(OP_W), .USE_TREE(1'b1)) u_mac_top (
      .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .clr(clr),
      .op_x(op_x), .op_y(op_y), .res_vld(res_vld), .res(res)
   );

   int    total = 0;
   int    bad   = 0;
   int    model = 0;
   bit    p1v = 0, p2v = 0;
   int    p1a = 0, p2a = 0;
   string p1t = "R5", p2t = "R5";
   int unsigned lcg = 32'h1234_5678;
   bit    finished = 0;

   function automatic int rnd(input int lo, input int hi);
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      return lo + int'((lcg >> 8) % unsigned'(hi - lo + 1));
   endfunction

   task automatic check(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // one cycle: check the slot from two calls earlier, then drive new inputs
   task automatic step(input bit v, input bit c, input int x, input int y, input string tag);
      @(negedge clk);
      check("R4", int'(res_vld), int'(p2v));
      check(p2t, int'(res), p2a);
      if (v) model = (c ? x * y : model + x * y) & MASK;
      p2v = p1v; p2a = p1a; p2t = p1t;
      p1v = v;   p1a = model; p1t = v ? tag : "R5";
      in_vld = v; clr = c;
      op_x = OP_W'(x); op_y = OP_W'(y);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R6 reset state
      check("R6", int'(res), 0);
      check("R6", int'(res_vld), 0);
      rst_n = 1'b1;

      // R1 / R8 exhaustive signed products, each with clear
      for (int x = XMIN; x <= XMAX; x++)
         for (int y = XMIN; y <= XMAX; y++)
            step(1, 1, x, y,
                 (x == XMIN || x == XMAX || y == XMIN || y == XMAX) ? "R8" : "R1");

      // R8 most negative squared, isolated
      step(1, 1, XMIN, XMIN, "R8");
      step(0, 0, 0, 0, "R5");

      // R2 accumulation with varied operands
      step(1, 1, 0, 0, "R2");
      for (int i = 0; i < 200; i++) step(1, 0, rnd(XMIN, XMAX), rnd(XMIN, XMAX), "R2");

      // R7 wraparound, positive and negative directions
      step(1, 1, XMAX, XMAX, "R7");
      for (int i = 0; i < 12; i++) step(1, 0, XMAX, XMAX, "R7");
      step(1, 1, XMIN, XMAX, "R7");
      for (int i = 0; i < 12; i++) step(1, 0, XMIN, XMAX, "R7");

      // R3 back-to-back dot products, clear with no gap
      for (int d = 0; d < 40; d++) begin
         step(1, 1, rnd(XMIN, XMAX), rnd(XMIN, XMAX), "R3");
         step(1, 0, rnd(XMIN, XMAX), rnd(XMIN, XMAX), "R3");
         step(1, 0, rnd(XMIN, XMAX), rnd(XMIN, XMAX), "R3");
      end

      // R9 / R5 idle cycles with arbitrary clr and operands
      for (int k = 0; k < 60; k++) begin
         for (int g = 0; g < rnd(1, 4); g++)
            step(0, bit'(rnd(0, 1)), rnd(XMIN, XMAX), rnd(XMIN, XMAX), "R5");
         step(1, 0, rnd(XMIN, XMAX), rnd(XMIN, XMAX), "R9");
      end

      // R4 latency over irregular valid pattern
      for (int i = 0; i < 300; i++)
         step(bit'(rnd(0, 1)), bit'(rnd(0, 3) == 0), rnd(XMIN, XMAX), rnd(XMIN, XMAX), "R4");

      for (int i = 0; i < 4; i++) step(0, 0, 0, 0, "R5");

      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(200000 * 5.0);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule